// File: doc/BRIEF.md
# DMA channel transfer counter

This block keeps the number of transfers a DMA channel still has to run. Software loads a 16-bit count through a halfword register port while the channel is disabled. The channel engine then sends a one-cycle strobe after each finished transfer. Each strobe accepted while the channel is enabled lowers the count by one.

A loaded value N gives N+1 transfers. The last one takes the count from zero to all ones. That step raises a one-cycle completion pulse and an end-of-transfer level, which tells the channel logic to drop the enable. In ring mode the count is not a limit: it runs down, wraps through zero and raises no completion.

A cascade pulse can start a linked channel. It fires either after every accepted transfer or only at final completion. Readback always shows the live count, one cycle late.

Top module: `dma_tc_counter`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `done_o`, `eot_o`, `casc_o` and `acc_err_o` are all low.
- R2: A write with `wr_size_i` = 2'b01 (halfword) and `wr_addr0_i` = 0, while `chan_en_i` is low, loads `wr_data_i`. The new value shows on `rd_data_o` two clock edges after the write cycle.
- R3: A well-formed write while `chan_en_i` is high leaves the count unchanged and does not set `acc_err_o`.
- R4: A write with `wr_size_i` other than 2'b01, or with `wr_addr0_i` = 1, is discarded and sets `acc_err_o` on the next edge. The flag stays high until reset.
- R5: Each `xfer_done_i` strobe accepted while `chan_en_i` is high and `eot_o` is low lowers the count by one. `rd_data_o` shows the count as it stood one cycle earlier, so in the cycle right after a strobe it still shows the value from before the decrement.
- R6: In normal mode (`ring_mode_i` low), a loaded value N completes after N+1 accepted strobes. The strobe taken at count 0 leaves 16'hFFFF, raises `done_o` for exactly one cycle and sets `eot_o`. Both changes show in the cycle after that strobe.
- R7: `eot_o` stays high until a cycle with `chan_en_i` low, and it clears on the following edge. While `eot_o` is high, strobes do not change the count.
- R8: In ring mode, accepted strobes keep counting down and wrap from 0 to 16'hFFFF. `done_o` and `eot_o` stay low.
- R9: A strobe while `chan_en_i` is low does not change the count.
- R10: With `casc_en_i` high and `casc_mode_i` = 0 (each transfer), `casc_o` pulses one cycle after every accepted strobe.
- R11: With `casc_en_i` high and `casc_mode_i` = 1 (final), `casc_o` pulses only together with `done_o`. In ring mode it never pulses.
- R12: With `casc_en_i` low, `casc_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write request |
| wr_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_addr0_i | input | 1 | Lowest address bit of the access |
| wr_data_i | input | 16 | Write data |
| chan_en_i | input | 1 | Channel enable |
| ring_mode_i | input | 1 | Free-running wrap mode |
| casc_en_i | input | 1 | A linked channel is attached |
| casc_mode_i | input | 1 | 0: cascade each transfer, 1: cascade at completion |
| xfer_done_i | input | 1 | One-cycle strobe per finished transfer |
| rd_data_o | output | 16 | Count readback, one cycle late |
| done_o | output | 1 | Completion pulse |
| eot_o | output | 1 | End of transfer; requests disable |
| casc_o | output | 1 | Start pulse for the linked channel |
| acc_err_o | output | 1 | Sticky flag for a bad-size or misaligned write |

## Verification
A wrong internal count shows on `rd_data_o` one cycle after it forms. The per-cycle reference comparison therefore catches a bad load, a missed decrement or a wrong wrap within two edges. A bad underflow test shows up sooner, in the next cycle: as a missing or extra `done_o`, a wrong `eot_o` level, or a `casc_o` pulse that does not match the selected trigger. If the end-of-transfer hold fails, counting continues past 16'hFFFF. That is visible on readback at the first strobe that arrives after completion.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic {
    CASC_EACH  = 1'b0,
    CASC_FINAL = 1'b1
  } casc_mode_e;

  typedef struct packed {
    logic accept;
    logic underflow;
  } xfer_evt_t;
endpackage

// File: rtl/dma_tc_wr_guard.sv
module dma_tc_wr_guard
  import dma_tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic              wr_addr0_i,
  input  logic              chan_en_i,
  output logic              load_o,
  output logic              err_o
);
  logic shape_ok;
  logic err_q;

  assign shape_ok = (acc_size_e'(wr_size_i) == SZ_HALF) && !wr_addr0_i;
  // well-formed writes are dropped silently while the channel runs
  assign load_o   = wr_en_i && shape_ok && !chan_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_q <= 1'b0;
    else if (wr_en_i && !shape_ok) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/dma_tc_core.sv
module dma_tc_core
  import dma_tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             xfer_i,
  input  logic             chan_en_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] cnt_o,
  output xfer_evt_t        evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept          = xfer_i && chan_en_i && !halt_i;
  assign evt_o.accept    = accept;
  assign evt_o.underflow = accept && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (accept) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_tc_readback.sv
module dma_tc_readback #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LAG   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] rd_o
);
  generate
    if (LAG == 0) begin : g_direct
      assign rd_o = cnt_i;
    end else begin : g_lag
      logic [CNT_W-1:0] stage_q [LAG];
      for (genvar i = 0; i < LAG; i++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= '0;
          else         stage_q[i] <= (i == 0) ? cnt_i : stage_q[(i == 0) ? 0 : i-1];
        end
      end
      assign rd_o = stage_q[LAG-1];
    end
  endgenerate
endmodule

// File: rtl/dma_tc_event.sv
module dma_tc_event
  import dma_tc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  xfer_evt_t evt_i,
  input  logic      ring_i,
  input  logic      chan_en_i,
  input  logic      casc_en_i,
  input  logic      casc_mode_i,
  output logic      done_o,
  output logic      eot_o,
  output logic      casc_o
);
  logic finish;
  logic casc_hit;
  logic done_q, eot_q, casc_q;

  // ring mode never finishes
  assign finish = evt_i.underflow && !ring_i;

  always_comb begin
    unique case (casc_mode_e'(casc_mode_i))
      CASC_EACH:  casc_hit = evt_i.accept;
      CASC_FINAL: casc_hit = finish;
      default:    casc_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      eot_q  <= 1'b0;
      casc_q <= 1'b0;
    end else begin
      done_q <= finish;
      casc_q <= casc_en_i && casc_hit;
      if (!chan_en_i)  eot_q <= 1'b0;
      else if (finish) eot_q <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign eot_o  = eot_q;
  assign casc_o = casc_q;
endmodule

// File: rtl/dma_tc_counter.sv
module dma_tc_counter
  import dma_tc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RD_LAG = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_size_i,
  input  logic             wr_addr0_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             chan_en_i,
  input  logic             ring_mode_i,
  input  logic             casc_en_i,
  input  logic             casc_mode_i,
  input  logic             xfer_done_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             done_o,
  output logic             eot_o,
  output logic             casc_o,
  output logic             acc_err_o
);
  logic             load;
  logic [CNT_W-1:0] cnt_q;
  xfer_evt_t        evt;
  logic             eot;

  dma_tc_wr_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_size_i  (wr_size_i),
    .wr_addr0_i (wr_addr0_i),
    .chan_en_i  (chan_en_i),
    .load_o     (load),
    .err_o      (acc_err_o)
  );

  dma_tc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wr_data_i),
    .xfer_i     (xfer_done_i),
    .chan_en_i  (chan_en_i),
    .halt_i     (eot),
    .cnt_o      (cnt_q),
    .evt_o      (evt)
  );

  dma_tc_readback #(.CNT_W(CNT_W), .LAG(RD_LAG)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_q),
    .rd_o   (rd_data_o)
  );

  dma_tc_event u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .ring_i      (ring_mode_i),
    .chan_en_i   (chan_en_i),
    .casc_en_i   (casc_en_i),
    .casc_mode_i (casc_mode_i),
    .done_o      (done_o),
    .eot_o       (eot),
    .casc_o      (casc_o)
  );

  assign eot_o = eot;
endmodule

// File: rtl/dma_tc_counter_chk.sv
module dma_tc_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             chan_en_i,
  input logic             ring_mode_i,
  input logic             casc_mode_i,
  input logic             xfer_done_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             done_o,
  input logic             eot_o,
  input logic             casc_o,
  input logic             acc_err_o
);
  // R3
  en_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_en_i && !xfer_done_i) |=> cnt_q == $past(cnt_q));

  // R9
  idle_strobe_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_en_i && !wr_en_i) |=> cnt_q == $past(cnt_q));

  // R4
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |=> acc_err_o);

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_sets_eot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (eot_o && cnt_q == '1));

  // R7
  eot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> !eot_o);

  // R7
  eot_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_o && chan_en_i) |=> cnt_q == $past(cnt_q));

  // R8
  ring_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_mode_i |=> !done_o);

  // R11
  casc_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_mode_i |=> (!casc_o || done_o));
endmodule

bind dma_tc_counter dma_tc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .chan_en_i   (chan_en_i),
  .ring_mode_i (ring_mode_i),
  .casc_mode_i (casc_mode_i),
  .xfer_done_i (xfer_done_i),
  .cnt_q       (cnt_q),
  .done_o      (done_o),
  .eot_o       (eot_o),
  .casc_o      (casc_o),
  .acc_err_o   (acc_err_o)
);

// File: tb/dma_tc_counter_test.sv
module dma_tc_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'b01;
  logic        wr_addr0 = 1'b0;
  logic [15:0] wr_data = '0;
  logic        chan_en = 1'b0;
  logic        ring = 1'b0;
  logic        casc_en = 1'b0;
  logic        casc_mode = 1'b0;
  logic        xfer = 1'b0;
  logic [15:0] rd_data;
  logic        done, eot, casc, acc_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  dma_tc_counter uut (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_en_i (wr_en), .wr_size_i (wr_size), .wr_addr0_i (wr_addr0),
    .wr_data_i (wr_data), .chan_en_i (chan_en), .ring_mode_i (ring),
    .casc_en_i (casc_en), .casc_mode_i (casc_mode), .xfer_done_i (xfer),
    .rd_data_o (rd_data), .done_o (done), .eot_o (eot), .casc_o (casc),
    .acc_err_o (acc_err)
  );

  // behavioural reference
  logic [15:0] m_cnt, m_rd;
  logic        m_done, m_eot, m_casc, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_rd <= 0; m_done <= 0; m_eot <= 0; m_casc <= 0; m_err <= 0;
    end else begin
      bit good, take, last;
      good = (wr_size == 2'b01) && !wr_addr0;
      take = xfer && chan_en && !m_eot;
      last = take && (m_cnt == 0) && !ring;
      m_rd <= m_cnt;
      if (wr_en && !good) m_err <= 1;
      if (wr_en && good && !chan_en) m_cnt <= wr_data;
      else if (take) m_cnt <= m_cnt - 16'd1;
      m_done <= last;
      m_casc <= take && casc_en && (casc_mode ? last : 1'b1);
      if (!chan_en) m_eot <= 0;
      else if (last) m_eot <= 1;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(phase, "rd_data", rd_data, m_rd);
    check(phase, "done", done, m_done);
    check(phase, "eot", eot, m_eot);
    check(phase, "casc", casc, m_casc);
    check(phase, "acc_err", acc_err, m_err);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      wr_en = 0; xfer = 0;
    end
  endtask

  task automatic write(logic [15:0] d, logic [1:0] sz, logic a0);
    wr_en = 1; wr_data = d; wr_size = sz; wr_addr0 = a0;
    tick(1);
    wr_size = 2'b01; wr_addr0 = 0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      xfer = 1;
      tick(1);
      tick(1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(1);
    check("R1", "reset rd", rd_data, 0);
    check("R1", "reset flags", {done, eot, casc, acc_err}, 0);

    phase = "R2";
    write(16'd3, 2'b01, 0);
    tick(1);
    check("R2", "loaded", rd_data, 3);

    phase = "R3";
    chan_en = 1; casc_en = 1; casc_mode = 0;
    tick(1);
    write(16'd100, 2'b01, 0);
    tick(2);
    check("R3", "write while enabled", rd_data, 3);
    check("R3", "no err", acc_err, 0);

    phase = "R5";
    xfer = 1;
    tick(1);
    check("R5", "stale readback", rd_data, 3);
    check("R10", "casc each", casc, 1);
    tick(1);
    check("R5", "decremented", rd_data, 2);
    phase = "R10";
    strobe(2);
    phase = "R6";
    xfer = 1;
    tick(1);
    check("R6", "done pulse", done, 1);
    check("R6", "eot set", eot, 1);
    tick(1);
    check("R6", "done single", done, 0);
    check("R6", "underflow value", rd_data, 16'hFFFF);

    phase = "R7";
    strobe(2);
    check("R7", "halted", rd_data, 16'hFFFF);
    chan_en = 0;
    tick(1);
    tick(1);
    check("R7", "eot cleared", eot, 0);

    phase = "R9";
    strobe(2);
    check("R9", "idle strobe", rd_data, 16'hFFFF);

    phase = "R4";
    write(16'd7, 2'b00, 0);
    write(16'd7, 2'b01, 1);
    write(16'd7, 2'b10, 0);
    tick(2);
    check("R4", "err sticky", acc_err, 1);
    check("R4", "discarded", rd_data, 16'hFFFF);

    phase = "R11";
    write(16'd1, 2'b01, 0);
    chan_en = 1; casc_mode = 1;
    tick(1);
    strobe(1);
    check("R11", "no early casc", casc, 0);
    xfer = 1;
    tick(1);
    check("R11", "final casc", casc, 1);
    tick(1);
    chan_en = 0;
    tick(2);

    phase = "R12";
    casc_en = 0; casc_mode = 0;
    write(16'd2, 2'b01, 0);
    chan_en = 1;
    tick(1);
    strobe(3);
    check("R12", "no casc", casc, 0);
    chan_en = 0;
    tick(2);

    phase = "R8";
    write(16'd1, 2'b01, 0);
    ring = 1; chan_en = 1; casc_en = 1; casc_mode = 1;
    tick(1);
    strobe(5);
    tick(1);
    check("R8", "ring wrap", rd_data, 16'hFFFC);
    check("R8", "no done/eot", {done, eot}, 0);
    chan_en = 0; ring = 0;
    tick(3);

    finish_up();
  end
endmodule